// File: doc/BRIEF.md
# FIFO Status and Interrupt Controller

This block puts a synchronous first-in first-out buffer behind a small word-addressed register port, and adds the logic that reports how the buffer is doing. Each cycle it forms a six-bit live condition word from the fill level and from the push and pop handshakes: empty, full, near-empty, near-full, a rejected push and a rejected pop. Each live bit is copied into a sticky event bit. Software clears an event bit by writing a one to its position.

A seven-bit enable word chooses which events may raise the host interrupt. Bit 6 of that word turns on all six at once. The interrupt is driven by a two-state machine. `IRQ_IDLE` moves to `IRQ_ACTIVE` (transition "raise") when an enabled event bit changes from 0 to 1. `IRQ_ACTIVE` goes back to `IRQ_IDLE` (transition "release") once every event bit that caused it has been cleared. Otherwise each state holds.

Software polls the fill level and the condition word. It sets the two thresholds and the enable word. It services the interrupt by reading the event word and writing back the bits it has handled.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: Condition bits share one layout in the status, event and enable words: bit 0 empty (level 0), bit 1 full (level equals DEPTH), bit 2 near-empty, bit 3 near-full, bit 4 rejected push, bit 5 rejected pop. The fill level never exceeds DEPTH.
- R2: Near-full is 1 only when the level is strictly greater than the near-full threshold. Near-empty is 1 only when the level is strictly less than the near-empty threshold.
- R3: A push while the buffer is full sets status bit 4 in that cycle only. The data is dropped and the level does not change.
- R4: A pop while the buffer is empty sets status bit 5 in that cycle only. The read data keeps its previous value and the level stays 0.
- R5: An event bit becomes 1 at the clock edge where its status bit is 1, and it stays 1 after the condition has gone.
- R6: Writing 1 to an event bit clears it and writing 0 leaves it unchanged. If the condition is still active in the cycle of the clear, the bit stays 1.
- R7: The interrupt rises when an event bit goes from 0 to 1 while its enable is set. Enabling a bit that is already 1 raises nothing.
- R8: Enable bit 6 enables all six conditions, whatever bits 5..0 hold.
- R9: The interrupt stays high until all event bits that caused it are 0, and then it falls.
- R10: Register map by word address: 0 fill level (read-only), 1 status (read-only), 2 event (write one to clear), 3 enable, 4 near-full threshold, 5 near-empty threshold. Other addresses read 0. Reset gives enable 0, near-full threshold DEPTH-2 and near-empty threshold 2.
- R11: Accepted data is popped in the order it was pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Push request |
| wr_data | input | W | Push data |
| rd_en | input | 1 | Pop request |
| rd_data | output | W | Registered pop data |
| reg_addr | input | 3 | Register word address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 1 | Level interrupt to the host |

## Verification
The assertions assume that the push, pop and register strobes are known values from the first clock after reset. They also assume that the write data and address are steady around the edge at which a strobe is sampled. The bench meets this by changing every input only on the falling clock edge and holding it for a full cycle. It reads the combinational status word in the middle of the low phase, so a one-cycle rejected-push or rejected-pop pulse can be seen before it goes away.

// File: rtl/fsic_pkg.sv
package fsic_pkg;
    localparam int NCOND   = 6;
    localparam int C_EMPTY = 0;
    localparam int C_FULL  = 1;
    localparam int C_NEMP  = 2;
    localparam int C_NFUL  = 3;
    localparam int C_OVF   = 4;
    localparam int C_UDF   = 5;
    localparam int IEN_ALL = 6;
    localparam int REG_W   = 32;

    typedef enum logic [2:0] {
        A_LEVEL  = 3'd0,
        A_STATUS = 3'd1,
        A_EVENT  = 3'd2,
        A_IEN    = 3'd3,
        A_NFUL   = 3'd4,
        A_NEMP   = 3'd5
    } addr_e;

    typedef enum logic {
        IRQ_IDLE,
        IRQ_ACTIVE
    } irq_state_e;
endpackage

// File: rtl/fsic_store.sv
module fsic_store #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [W-1:0]     wr_data,
    input  logic             rd_en,
    output logic [W-1:0]     rd_data,
    output logic [LVL_W-1:0] level
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic             is_full, is_empty, do_wr, do_rd;

    assign is_full  = (level == FULL_LVL);
    assign is_empty = (level == '0);
    assign do_wr    = wr_en && !is_full;
    assign do_rd    = rd_en && !is_empty;

    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            level   <= '0;
            rd_data <= '0;
        end else begin
            if (do_wr) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (do_rd) begin
                rptr    <= (rptr == LAST) ? '0 : rptr + 1'b1;
                rd_data <= mem[rptr];
            end
            unique case ({do_wr, do_rd})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL_LVL);
    assert_drop_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_full && !rd_en) |=> (level == FULL_LVL));
    assert_hold_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && is_empty) |=> ($stable(rd_data) && level == '0));
endmodule

// File: rtl/fsic_monitor.sv
module fsic_monitor
    import fsic_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic [LVL_W-1:0] level,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [LVL_W-1:0] nful_thr,
    input  logic [LVL_W-1:0] nemp_thr,
    output logic [NCOND-1:0] status
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    always_comb begin
        status         = '0;
        status[C_EMPTY] = (level == '0);
        status[C_FULL]  = (level == FULL_LVL);
        status[C_NEMP]  = (level < nemp_thr);
        status[C_NFUL]  = (level > nful_thr);
        status[C_OVF]   = wr_en && (level == FULL_LVL);
        status[C_UDF]   = rd_en && (level == '0);
    end
endmodule

// File: rtl/fsic_irq.sv
module fsic_irq
    import fsic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCOND-1:0] status,
    input  logic [NCOND-1:0] clr,
    input  logic [NCOND:0]   ien,
    output logic [NCOND-1:0] events,
    output logic             irq
);
    irq_state_e       state_q, state_d;
    logic [NCOND-1:0] ev_prev, cause_q, cause_d, rising, eff_en, pending;

    assign eff_en  = ien[IEN_ALL] ? '1 : ien[NCOND-1:0];
    assign rising  = events & ~ev_prev;
    assign pending = rising & eff_en;
    assign cause_d = (cause_q | pending) & events;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            events  <= '0;
            ev_prev <= '0;
            cause_q <= '0;
        end else begin
            events  <= (events & ~clr) | status;
            ev_prev <= events;
            cause_q <= cause_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (pending != '0) state_d = IRQ_ACTIVE;
            IRQ_ACTIVE: if (cause_d == '0) state_d = IRQ_IDLE;
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_ACTIVE);
    end

    assert_sticky_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status != '0) |=> ((events & $past(status)) == $past(status)));
    assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr & ~status) != '0) |=> ((events & $past(clr & ~status)) == '0));
    assert_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((events & ~clr) != '0) |=> ((events & $past(events & ~clr)) == $past(events & ~clr)));
    assert_irq_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pending != '0) |=> irq);
    assert_irq_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && events == '0) |=> !irq);
endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
    import fsic_pkg::*;
#(
    parameter int W           = 8,
    parameter int DEPTH       = 8,
    parameter int NFUL_RESET  = DEPTH - 2,
    parameter int NEMP_RESET  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [W-1:0]     wr_data,
    input  logic             rd_en,
    output logic [W-1:0]     rd_data,
    input  logic [2:0]       reg_addr,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq
);
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic [LVL_W-1:0] level, nful_thr, nemp_thr;
    logic [NCOND-1:0] status, events, clr;
    logic [NCOND:0]   ien;
    logic             unused_wdata;

    assign unused_wdata = ^reg_wdata[REG_W-1:NCOND+1];

    fsic_store #(.W(W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .level(level)
    );

    fsic_monitor #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_monitor (
        .level(level), .wr_en(wr_en), .rd_en(rd_en),
        .nful_thr(nful_thr), .nemp_thr(nemp_thr), .status(status)
    );

    fsic_irq u_irq (
        .clk(clk), .rst_n(rst_n), .status(status), .clr(clr),
        .ien(ien), .events(events), .irq(irq)
    );

    assign clr = (reg_we && reg_addr == A_EVENT) ? reg_wdata[NCOND-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien      <= '0;
            nful_thr <= LVL_W'(NFUL_RESET);
            nemp_thr <= LVL_W'(NEMP_RESET);
        end else if (reg_we) begin
            unique case (reg_addr)
                A_IEN:   ien      <= reg_wdata[NCOND:0];
                A_NFUL:  nful_thr <= reg_wdata[LVL_W-1:0];
                A_NEMP:  nemp_thr <= reg_wdata[LVL_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_LEVEL:  reg_rdata = REG_W'(level);
            A_STATUS: reg_rdata = REG_W'(status);
            A_EVENT:  reg_rdata = REG_W'(events);
            A_IEN:    reg_rdata = REG_W'(ien);
            A_NFUL:   reg_rdata = REG_W'(nful_thr);
            A_NEMP:   reg_rdata = REG_W'(nemp_thr);
            default:  reg_rdata = '0;
        endcase
    end

    assert_ien_readback_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_IEN) |=> (ien == $past(reg_wdata[NCOND:0])));
endmodule

// File: tb/test_fifo_irq_ctrl.sv
module test_fifo_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, reg_we = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        irq;
    int          checks = 0, errors = 0;

    always #4 clk = ~clk;

    fifo_irq_ctrl #(.W(8), .DEPTH(8)) i_fifo_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rreg(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk); reg_addr = a; #1; v = reg_rdata;
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pop(output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; d = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rreg(3'd0, v); chk("R10 level reset", v, 32'd0);
        rreg(3'd3, v); chk("R10 enable reset", v, 32'd0);
        rreg(3'd4, v); chk("R10 near-full reset", v, 32'd6);
        rreg(3'd5, v); chk("R10 near-empty reset", v, 32'd2);
        rreg(3'd6, v); chk("R10 unmapped address", v, 32'd0);
        rreg(3'd1, v); chk("R1 status empty", v, 32'h05);
        rreg(3'd2, v); chk("R5 event after reset", v, 32'h05);
        chk("R10 irq reset", irq, 1'b0);
    endtask

    task automatic t_order;
        logic [31:0] v;
        logic [7:0]  d;
        push(8'hA1); push(8'hB2); push(8'hC3);
        rreg(3'd0, v); chk("R11 level after pushes", v, 32'd3);
        rreg(3'd1, v); chk("R2 mid level no flags", v, 32'h00);
        pop(d); chk("R11 first out", d, 8'hA1);
        pop(d); chk("R11 second out", d, 8'hB2);
        pop(d); chk("R11 third out", d, 8'hC3);
    endtask

    task automatic t_thresholds_overflow;
        logic [31:0] v;
        logic [7:0]  d;
        for (int i = 0; i < 8; i++) begin
            push(8'h10 + 8'(i));
            rreg(3'd1, v);
            case (i + 1)
                1: chk("R2 level1 near-empty", v, 32'h04);
                2: chk("R2 level2 not near-empty", v, 32'h00);
                6: chk("R2 level6 not near-full", v, 32'h00);
                7: chk("R2 level7 near-full", v, 32'h08);
                8: chk("R1 level8 full", v, 32'h0A);
                default: ;
            endcase
        end
        @(negedge clk); wr_en = 1'b1; wr_data = 8'hEE; reg_addr = 3'd1; #1;
        chk("R3 reject push pulse", reg_rdata, 32'h1A);
        @(negedge clk); wr_en = 1'b0; #1;
        chk("R3 pulse one cycle", reg_rdata, 32'h0A);
        rreg(3'd0, v); chk("R3 level unchanged", v, 32'd8);
        rreg(3'd2, v); chk("R5 overflow event", v[4], 32'd1);
        for (int i = 0; i < 8; i++) begin
            pop(d); chk("R3 dropped push absent / R11", d, 8'h10 + 8'(i));
        end
    endtask

    task automatic t_underflow;
        logic [31:0] v;
        @(negedge clk); rd_en = 1'b1; reg_addr = 3'd1; #1;
        chk("R4 reject pop pulse", reg_rdata, 32'h25);
        @(negedge clk); rd_en = 1'b0; #1;
        chk("R4 pulse one cycle", reg_rdata, 32'h05);
        chk("R4 data held", rd_data, 8'h17);
        rreg(3'd0, v); chk("R4 level stays 0", v, 32'd0);
        rreg(3'd2, v); chk("R5 all events seen", v, 32'h3F);
    endtask

    task automatic t_w1c;
        logic [31:0] v;
        for (int i = 0; i < 4; i++) push(8'h40 + 8'(i));
        rreg(3'd2, v); chk("R5 events sticky at level 4", v, 32'h3F);
        wreg(3'd2, 32'h0);  rreg(3'd2, v); chk("R6 write zero no effect", v, 32'h3F);
        wreg(3'd2, 32'h30); rreg(3'd2, v); chk("R6 partial clear", v, 32'h0F);
        wreg(3'd2, 32'h0F); rreg(3'd2, v); chk("R6 full clear", v, 32'h00);
    endtask

    task automatic t_irq;
        logic [31:0] v;
        wreg(3'd3, 32'h10);
        rreg(3'd3, v); chk("R10 enable readback", v, 32'h10);
        for (int i = 0; i < 4; i++) push(8'h50 + 8'(i));
        idle(2); chk("R7 disabled events no irq", irq, 1'b0);
        push(8'hEE);
        idle(2); chk("R7 enabled rise raises irq", irq, 1'b1);
        wreg(3'd2, 32'h10);
        idle(2); chk("R9 irq released after clear", irq, 1'b0);
        rreg(3'd2, v); chk("R6 other events kept", v, 32'h0A);
        wreg(3'd3, 32'h02);
        idle(3); chk("R7 enable of set event no irq", irq, 1'b0);
    endtask

    task automatic t_all;
        logic [31:0] v;
        logic [7:0]  d;
        wreg(3'd3, 32'h40);
        wreg(3'd2, 32'h3F);
        rreg(3'd2, v); chk("R6 set wins while full", v, 32'h0A);
        chk("R8 no rise no irq", irq, 1'b0);
        for (int i = 0; i < 8; i++) pop(d);
        idle(2); chk("R8 all-enable catches near-empty", irq, 1'b1);
        wreg(3'd2, 32'h3F);
        idle(2); chk("R9 irq held while cause active", irq, 1'b1);
        rreg(3'd2, v); chk("R6 set wins while empty", v, 32'h05);
        for (int i = 0; i < 3; i++) push(8'h60 + 8'(i));
        wreg(3'd2, 32'h3F);
        idle(2); chk("R9 irq falls after causes cleared", irq, 1'b0);
    endtask

    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_order();
        t_thresholds_overflow();
        t_underflow();
        t_w1c();
        t_irq();
        t_all();
        idle(2);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule